// File: doc/BRIEF.md
# Asymmetric Latching Contact Debouncer

This block cleans the level of one mechanical contact that pulls its line low when it closes. The raw level first passes through a two-flop synchronizer. It is then sampled on enable ticks. The clean output changes only once four consecutive samples disagree with it. A sample that agrees with the output cancels the pending change, so bounce bursts shorter than four samples never reach the output.

The sampling rate depends on which way the output would move. A falling output (contact closing, the attack) is sampled on every base tick. A rising output (contact opening, the release) is sampled only on every N-th base tick. A swap input exchanges the two rates. A latch input freezes sampling while the output is low, so a single closure stays held until the latch is cleared. The divided tick is driven out so that sibling debouncers can share the same slow timing.

Top module: `contact_debouncer`

## Requirements
- R1: After reset, `clean_no` is 1 (open). The prescaler is cleared, so the first `slow_tick_o` pulse coincides with the DIV_N-th `tick_i` pulse after reset.
- R2: `slow_tick_o` is high only in a cycle where `tick_i` is high. It occurs on exactly every DIV_N-th `tick_i` pulse, and the prescaler keeps running while sampling is frozen.
- R3: With `swap_i`=0, once `raw_ni` has gone low and settled through the two-flop synchronizer, `clean_no` falls on the 4th `tick_i` sample of that level and not before.
- R4: With `swap_i`=0, a rising `clean_no` needs four consecutive `slow_tick_o` samples of a high input. `tick_i` pulses that do not coincide with `slow_tick_o` take no sample during the release.
- R5: Any sample equal to `clean_no` clears the pending count. A disagreement lasting fewer than four samples leaves `clean_no` unchanged.
- R6: With `swap_i`=1, the attack samples only on `slow_tick_o` and the release samples on every `tick_i`.
- R7: With `latch_i`=1, the attack still works. While `clean_no` is 0, sampling stops, and `clean_no` stays 0 even after `raw_ni` returns high.
- R8: When `latch_i` returns to 0, sampling resumes at the next qualifying tick. A release then takes four qualifying ticks.
- R9: `clean_no` changes only on the clock edge that follows a cycle with `tick_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Base sampling enable, one cycle wide |
| raw_ni | input | 1 | Raw contact level, low when closed |
| latch_i | input | 1 | Hold the output low once it has fallen |
| swap_i | input | 1 | 1 gives slow attack and fast release |
| clean_no | output | 1 | Debounced contact level, low when closed |
| slow_tick_o | output | 1 | Base tick divided by DIV_N, shareable |

## Verification
The assertions assume that `tick_i` is a single-cycle pulse and that `latch_i` and `swap_i` change only between samples. The bench generates `tick_i` as one cycle in every four and changes every input at a falling clock edge just after a tick has been consumed. This gives the synchronizer two full edges to settle before the next sample, so each scenario knows exactly which sample first sees a new level.

// File: rtl/debounce_pkg.sv
package debounce_pkg;
  typedef enum logic {
    RATE_FAST = 1'b0,
    RATE_SLOW = 1'b1
  } rate_e;

  localparam int unsigned DEF_HOLD   = 4;
  localparam int unsigned DEF_STAGES = 2;
endpackage

// File: rtl/debounce_sync.sv
module debounce_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shift_q <= {STAGES{RESET_VAL}};
    else         shift_q <= {shift_q[STAGES-2:0], d_i};
  end

  assign q_o = shift_q[STAGES-1];
endmodule

// File: rtl/debounce_prescaler.sv
module debounce_prescaler #(
  parameter int unsigned DIV_N = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic slow_tick_o
);
  localparam int unsigned CW = (DIV_N > 2) ? $clog2(DIV_N) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_N - 1);

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (tick_i) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

  assign slow_tick_o = tick_i & wrap;
endmodule

// File: rtl/debounce_filter.sv
module debounce_filter #(
  parameter int unsigned HOLD = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_en_i,
  input  logic sample_i,
  output logic level_o
);
  localparam int unsigned CW = (HOLD > 2) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] run_q;
  logic          level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 1'b1;
      run_q   <= '0;
    end else if (sample_en_i) begin
      if (sample_i == level_q) begin
        run_q <= '0;
      end else if (run_q == LAST) begin
        level_q <= sample_i;
        run_q   <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign level_o = level_q;
endmodule

// File: rtl/contact_debouncer.sv
module contact_debouncer
  import debounce_pkg::*;
#(
  parameter int unsigned DIV_N  = 4,
  parameter int unsigned HOLD   = DEF_HOLD,
  parameter int unsigned STAGES = DEF_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic raw_ni,
  input  logic latch_i,
  input  logic swap_i,
  output logic clean_no,
  output logic slow_tick_o
);
  logic  raw_sync;
  logic  slow_tick;
  logic  level;
  logic  frozen;
  logic  sel_tick;
  logic  sample_en;
  rate_e rate_sel;

  debounce_sync #(.STAGES(STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_ni),
    .q_o   (raw_sync)
  );

  debounce_prescaler #(.DIV_N(DIV_N)) u_presc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .slow_tick_o(slow_tick)
  );

  // Output high: next move is the attack; output low: the release.
  always_comb begin
    if (level) rate_sel = swap_i ? RATE_SLOW : RATE_FAST;
    else       rate_sel = swap_i ? RATE_FAST : RATE_SLOW;
  end

  assign sel_tick  = (rate_sel == RATE_SLOW) ? slow_tick : tick_i;
  assign frozen    = latch_i & ~level;
  assign sample_en = sel_tick & ~frozen;

  debounce_filter #(.HOLD(HOLD)) u_filt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sample_en_i(sample_en),
    .sample_i   (raw_sync),
    .level_o    (level)
  );

  assign clean_no    = level;
  assign slow_tick_o = slow_tick;
endmodule

// File: rtl/contact_debouncer_chk.sv
module contact_debouncer_chk #(
  parameter int unsigned DIV_N = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic raw_ni,
  input logic latch_i,
  input logic swap_i,
  input logic clean_no,
  input logic slow_tick_o
);
  logic [31:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gap_q <= '0;
    else if (tick_i) gap_q <= slow_tick_o ? '0 : gap_q + 1;
  end

  p_slow_in_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_tick_o |-> tick_i);

  p_slow_spacing_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_tick_o |-> (gap_q == DIV_N - 1));

  p_gap_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q < DIV_N);

  p_hold_no_tick_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(clean_no));

  p_release_slow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!swap_i && !clean_no && !slow_tick_o) |=> !clean_no);

  p_attack_slow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swap_i && clean_no && !slow_tick_o) |=> clean_no);

  p_latch_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_i && !clean_no) |=> !clean_no);

  p_raw_known_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(raw_ni));
endmodule

bind contact_debouncer contact_debouncer_chk #(.DIV_N(DIV_N)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .raw_ni     (raw_ni),
  .latch_i    (latch_i),
  .swap_i     (swap_i),
  .clean_no   (clean_no),
  .slow_tick_o(slow_tick_o)
);

// File: tb/contact_debouncer_bench.sv
module contact_debouncer_bench;
  localparam int unsigned DIV_N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic raw_n = 1'b1;
  logic latch = 1'b0;
  logic swap = 1'b0;
  logic clean_n;
  logic slow_tick;
  logic [1:0] tdiv;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdiv <= '0;
      tick <= 1'b0;
    end else begin
      tdiv <= tdiv + 1'b1;
      tick <= (tdiv == 2'd3);
    end
  end

  contact_debouncer #(.DIV_N(DIV_N)) u_contact_debouncer (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .tick_i     (tick),
    .raw_ni     (raw_n),
    .latch_i    (latch),
    .swap_i     (swap),
    .clean_no   (clean_n),
    .slow_tick_o(slow_tick)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Waits until n base ticks have been consumed; returns at the next falling edge.
  task automatic wait_fast(int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!tick);
      @(negedge clk);
    end
  endtask

  task automatic wait_slow(int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!slow_tick);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    int n;
    bit s;
    check("R1 reset level", clean_n, 1);
    n = 0;
    do begin
      do @(negedge clk); while (!tick);
      s = slow_tick;
      @(negedge clk);
      n++;
    end while (!s);
    check("R1 ticks to first slow", n, DIV_N);
    n = 0;
    do begin
      do @(negedge clk); while (!tick);
      s = slow_tick;
      @(negedge clk);
      n++;
    end while (!s);
    check("R2 ticks between slow", n, DIV_N);
  endtask

  task automatic t_attack();
    wait_fast(1);
    raw_n = 1'b0;
    wait_fast(3);
    check("R3 high after 3 fast", clean_n, 1);
    wait_fast(1);
    check("R3 low after 4 fast", clean_n, 0);
  endtask

  task automatic t_release();
    wait_fast(1);
    raw_n = 1'b1;
    wait_slow(3);
    check("R4 low after 3 slow", clean_n, 0);
    wait_slow(1);
    check("R4 high after 4 slow", clean_n, 1);
  endtask

  task automatic t_glitch();
    wait_fast(1);
    raw_n = 1'b0;
    wait_fast(3);
    raw_n = 1'b1;
    wait_fast(1);
    check("R5 bounce ignored", clean_n, 1);
    raw_n = 1'b0;
    wait_fast(3);
    check("R5 count restarted", clean_n, 1);
    wait_fast(1);
    check("R5 low after 4 clean", clean_n, 0);
    raw_n = 1'b1;
    wait_slow(4);
    check("R5 restore high", clean_n, 1);
  endtask

  task automatic t_swap();
    wait_fast(1);
    swap = 1'b1;
    raw_n = 1'b0;
    wait_slow(3);
    check("R6 swapped attack 3 slow", clean_n, 1);
    wait_slow(1);
    check("R6 swapped attack 4 slow", clean_n, 0);
    raw_n = 1'b1;
    wait_fast(3);
    check("R6 swapped release 3 fast", clean_n, 0);
    wait_fast(1);
    check("R6 swapped release 4 fast", clean_n, 1);
    swap = 1'b0;
  endtask

  task automatic t_latch();
    wait_fast(1);
    latch = 1'b1;
    raw_n = 1'b0;
    wait_fast(4);
    check("R7 attack with latch", clean_n, 0);
    raw_n = 1'b1;
    wait_slow(6);
    check("R7 held low", clean_n, 0);
    latch = 1'b0;
    wait_slow(3);
    check("R8 low after 3 slow", clean_n, 0);
    wait_slow(1);
    check("R8 high after 4 slow", clean_n, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_attack();
    t_release();
    t_glitch();
    t_swap();
    t_latch();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end
endmodule